// File: doc/BRIEF.md
# Masking RNG Seed Byte Loader

This block gathers the 128-bit seed used by the random bit generator that drives a cipher's side-channel countermeasures. Software supplies the seed one byte per bus write to a write-only data register. A read-only fill counter tells software how many bytes have been taken so far. Because that counter only moves once a byte has been fully taken, software uses it as its flow control: it writes a byte, polls the counter until the count moves, and then writes the next byte.

Each byte that is taken lands in the next free byte lane of the seed register, starting at the least significant lane. Taking a byte lasts a fixed, parameterised number of cycles, two by default. When the sixteenth byte lands, the block raises a seed-valid flag to the generator. That flag stays high until reset. A global enable bit in a control register belongs to the generator side. While that bit is set, the seed is frozen against further loading.

Top module: `rbg_seed_loader`

## Requirements
- R1: After a synchronous active-high reset, the fill count is 0, `seed_o` is all zeros, `seed_valid_o` is low and the enable bit reads 0.
- R2: A write to the seed data register (byte offset 0x4) is taken when the enable bit is clear, no byte is in flight and the count is below 16. The count read back is unchanged for the ACCEPT_CYCLES-1 clock edges that follow the write edge. It is one higher from edge ACCEPT_CYCLES after the write edge onward.
- R3: A taken byte is `bus_wdata[7:0]`, and bits 31:8 are ignored. It appears in `seed_o[8*n+7:8*n]`, where n is the count before it was taken. All other seed bits keep their values.
- R4: The fill count reads at byte offset 0x8 in bits 4:0, with zeros above. Writes to that offset change nothing.
- R5: A seed write made while the enable bit (bit 0 at byte offset 0x0) is set is ignored. Neither the count nor the seed changes.
- R6: Once the count is 16, further seed writes are ignored. The count stays 16 and the seed does not change.
- R7: `seed_valid_o` is high exactly when the count is 16. It stays high, whatever the enable bit does, until reset.
- R8: A seed write that arrives while an earlier byte is still being taken is ignored.
- R9: The enable bit reads back at offset 0x0 bit 0 and drives `gen_enable_o`. Reads of the seed data register and of any other offset return 0.
- R10: The count never exceeds 16, and it rises by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid in the access cycle |
| seed_o | output | 8*SEED_BYTES | Assembled seed, byte n in lane n |
| seed_valid_o | output | 1 | Seed complete |
| gen_enable_o | output | 1 | Generator enable bit |

## Verification
The assertions assume that accesses are word aligned and that the reset is held for at least one clock. They also assume that the count can change only through the internal acceptance timer, so the only thing that can move it is a taken write. The stimulus keeps to these assumptions. It drives one access per cycle on falling edges, always to one of the three defined offsets. It reads the counter in every idle cycle so that a behavioural model can compare the count cycle by cycle. It deliberately issues a write while a byte is in flight, writes while the enable bit is set, writes to the counter offset, and writes once the seed is full.

// File: rtl/seedld_pkg.sv
`timescale 1ns/1ps
package seedld_pkg;

    localparam int BYTE_W = 8;
    localparam int BUS_W  = 32;

    // Word indices of the register slots (byte offset = index * 4)
    localparam int WORD_CTRL  = 0;
    localparam int WORD_SEED  = 1;
    localparam int WORD_COUNT = 2;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SEED  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          target;
        logic [BYTE_W-1:0] lane;
        logic              ctrl_bit;
    } bus_req_t;

    function automatic reg_sel_e word_to_sel(input int unsigned word, input logic aligned);
        reg_sel_e s;
        if (!aligned)                      s = SEL_NONE;
        else if (word == WORD_CTRL)        s = SEL_CTRL;
        else if (word == WORD_SEED)        s = SEL_SEED;
        else if (word == WORD_COUNT)       s = SEL_COUNT;
        else                               s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/seedld_decode.sv
`timescale 1ns/1ps
module seedld_decode
    import seedld_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output bus_req_t          req_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_hi_data;

    assign word           = bus_addr[ADDR_W-1:2];
    assign unused_hi_data = ^bus_wdata[BUS_W-1:BYTE_W];

    always_comb begin
        req_o          = '0;
        req_o.wr       = bus_sel && bus_write;
        req_o.rd       = bus_sel && !bus_write;
        req_o.target   = word_to_sel(32'(word), bus_addr[1:0] == 2'b00);
        req_o.lane     = bus_wdata[BYTE_W-1:0];
        req_o.ctrl_bit = bus_wdata[0];
    end

endmodule

// File: rtl/seedld_ctrl.sv
`timescale 1ns/1ps
module seedld_ctrl
    import seedld_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    output logic     enable_o
);
    logic enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
        end else if (req_i.wr && req_i.target == SEL_CTRL) begin
            enable_q <= req_i.ctrl_bit;
        end
    end

    assign enable_o = enable_q;

endmodule

// File: rtl/seedld_accept.sv
`timescale 1ns/1ps
module seedld_accept
    import seedld_pkg::*;
#(
    parameter int ACCEPT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int TMR_W = (ACCEPT_CYCLES > 1) ? $clog2(ACCEPT_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ACCEPT_CYCLES - 1);

    logic              busy_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            byte_q <= '0;
        end else if (busy_q) begin
            if (tmr_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                tmr_q <= tmr_q - 1'b1;
            end
        end else if (start_i) begin
            busy_q <= 1'b1;
            tmr_q  <= TMR_LOAD;
            byte_q <= byte_i;
        end
    end

    assign busy_o   = busy_q;
    assign commit_o = busy_q && (tmr_q == '0);
    assign byte_o   = byte_q;

endmodule

// File: rtl/seedld_store.sv
`timescale 1ns/1ps
module seedld_store
    import seedld_pkg::*;
#(
    parameter int SEED_BYTES = 16,
    parameter int CNT_W      = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit_i,
    input  logic [BYTE_W-1:0]            byte_i,
    output logic [CNT_W-1:0]             count_o,
    output logic [BYTE_W*SEED_BYTES-1:0] seed_o,
    output logic                         full_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SEED_BYTES - 1);

    logic [CNT_W-1:0] count_q;
    logic             full_q;
    logic             take;

    assign take = commit_i && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            full_q  <= 1'b0;
        end else if (take) begin
            count_q <= count_q + 1'b1;
            if (count_q == LAST_IDX) begin
                full_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SEED_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (take && count_q == CNT_W'(g)) begin
                lane_q <= byte_i;
            end
        end
        assign seed_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

    assign count_o = count_q;
    assign full_o  = full_q;

endmodule

// File: rtl/rbg_seed_loader.sv
`timescale 1ns/1ps
module rbg_seed_loader
    import seedld_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int SEED_BYTES    = 16,
    parameter int ACCEPT_CYCLES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    output logic [BYTE_W*SEED_BYTES-1:0] seed_o,
    output logic                         seed_valid_o,
    output logic                         gen_enable_o
);
    localparam int CNT_W = $clog2(SEED_BYTES + 1);

    bus_req_t          req;
    logic              accept_start;
    logic              accept_busy;
    logic              accept_commit;
    logic [BYTE_W-1:0] accept_byte;
    logic [CNT_W-1:0]  fill_count;

    seedld_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req_o     (req)
    );

    seedld_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .enable_o (gen_enable_o)
    );

    // A byte is taken only while loading is open and the timer is idle
    assign accept_start = req.wr && (req.target == SEL_SEED) && !gen_enable_o
                          && !accept_busy && !seed_valid_o;

    seedld_accept #(.ACCEPT_CYCLES(ACCEPT_CYCLES)) u_accept (
        .clk      (clk),
        .rst      (rst),
        .start_i  (accept_start),
        .byte_i   (req.lane),
        .busy_o   (accept_busy),
        .commit_o (accept_commit),
        .byte_o   (accept_byte)
    );

    seedld_store #(.SEED_BYTES(SEED_BYTES), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit_i (accept_commit),
        .byte_i   (accept_byte),
        .count_o  (fill_count),
        .seed_o   (seed_o),
        .full_o   (seed_valid_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.target)
                SEL_CTRL:  bus_rdata = BUS_W'(gen_enable_o);
                SEL_COUNT: bus_rdata = BUS_W'(fill_count);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rbg_seed_loader_chk.sv
`timescale 1ns/1ps
module rbg_seed_loader_chk #(
    parameter int SEED_BYTES    = 16,
    parameter int CNT_W         = 5,
    parameter int ACCEPT_CYCLES = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [CNT_W-1:0]        count,
    input logic                    busy,
    input logic [8*SEED_BYTES-1:0] seed,
    input logic                    valid
);
    localparam int AGE_W = $clog2(ACCEPT_CYCLES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SEED_BYTES);
    localparam logic [AGE_W-1:0] LAST_AGE = AGE_W'(ACCEPT_CYCLES - 1);

    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || !busy) age <= '0;
        else              age <= age + 1'b1;
    end

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));

    p_hold_early_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && age != LAST_AGE) |=> $stable(count));

    p_commit_time_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && age == LAST_AGE && count != FULL) |=> (count == $past(count) + CNT_W'(1)));

    p_idle_no_move_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(count));

    p_seed_moves_with_count_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(seed) |-> (count == $past(count) + CNT_W'(1)));

    p_full_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (count == FULL) |=> (count == FULL && $stable(seed)));

    p_valid_match_r7: assert property (@(posedge clk) disable iff (rst)
        valid == (count == FULL));

    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

endmodule

bind rbg_seed_loader rbg_seed_loader_chk #(
    .SEED_BYTES    (SEED_BYTES),
    .CNT_W         (CNT_W),
    .ACCEPT_CYCLES (ACCEPT_CYCLES)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .count (fill_count),
    .busy  (accept_busy),
    .seed  (seed_o),
    .valid (seed_valid_o)
);

// File: tb/rbg_seed_loader_bench.sv
`timescale 1ns/1ps
module rbg_seed_loader_bench;
    localparam int SB  = 16;
    localparam int ACC = 2;
    localparam int AW  = 4;
    localparam logic [AW-1:0] A_CTRL = 4'h0;
    localparam logic [AW-1:0] A_SEED = 4'h4;
    localparam logic [AW-1:0] A_CNT  = 4'h8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [8*SB-1:0] seed_o;
    logic            seed_valid_o;
    logic            gen_enable_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rbg_seed_loader #(.ADDR_W(AW), .SEED_BYTES(SB), .ACCEPT_CYCLES(ACC)) u_rbg_seed_loader (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .seed_o       (seed_o),
        .seed_valid_o (seed_valid_o),
        .gen_enable_o (gen_enable_o)
    );

    // Behavioural reference model
    int              m_cnt = 0;
    logic [8*SB-1:0] m_seed = '0;
    bit              m_pend = 0;
    int              m_wait = 0;
    logic [7:0]      m_byte = '0;
    bit              m_en = 0;
    bit              m_valid = 0;

    always @(posedge clk) begin
        bit take;
        if (rst) begin
            m_cnt = 0; m_seed = '0; m_pend = 0; m_wait = 0; m_en = 0; m_valid = 0;
        end else begin
            take = bus_sel && bus_write && bus_addr == A_SEED && !m_en && !m_pend && m_cnt < SB;
            if (m_pend) begin
                if (m_wait == 0) begin
                    m_seed[m_cnt*8 +: 8] = m_byte;
                    m_cnt  = m_cnt + 1;
                    m_pend = 0;
                    if (m_cnt == SB) m_valid = 1;
                end else begin
                    m_wait = m_wait - 1;
                end
            end
            if (take) begin
                m_pend = 1;
                m_wait = ACC - 1;
                m_byte = bus_wdata[7:0];
            end
            if (bus_sel && bus_write && bus_addr == A_CTRL) m_en = bus_wdata[0];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        chk("R3", "seed vs model", seed_o, m_seed);
        chk("R7", "valid vs model", 128'(seed_valid_o), 128'(m_valid));
        chk("R9", "enable vs model", 128'(gen_enable_o), 128'(m_en));
        if (bus_sel && !bus_write && bus_addr == A_CNT)
            chk("R2", "count vs model", 128'(bus_rdata), 128'(m_cnt));
    end

    task automatic idle();
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        idle();
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0]     r;
        logic [8*SB-1:0] exp_seed;
        idle();
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "seed after reset", seed_o, '0);
        chk("R1", "valid after reset", 128'(seed_valid_o), 0);
        rd(A_CNT, r);  chk("R1", "count after reset", 128'(r), 0);
        rd(A_CTRL, r); chk("R1", "ctrl after reset", 128'(r), 0);
        idle();

        // R2 latency, R3 upper data bits ignored
        wr(A_SEED, 32'hFFFF_FF5A);
        rd(A_CNT, r); chk("R2", "count one edge after write", 128'(r), 0);
        rd(A_CNT, r); chk("R2", "count at commit edge", 128'(r), 1);
        chk("R3", "byte 0 lane", 128'(seed_o[7:0]), 128'(8'h5A));
        chk("R3", "upper lanes untouched", 128'(seed_o[8*SB-1:8]), 0);
        idle();

        // R8 write during acceptance is ignored
        wr(A_SEED, 32'h0000_0011);
        wr(A_SEED, 32'h0000_0099);
        cycles(4);
        rd(A_CNT, r); chk("R8", "count after busy write", 128'(r), 2);
        chk("R8", "byte 1 lane", 128'(seed_o[15:8]), 128'(8'h11));
        idle();

        // R5 writes ignored while enabled, R9 ctrl readback
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, r); chk("R9", "ctrl reads 1", 128'(r), 1);
        chk("R9", "gen_enable_o high", 128'(gen_enable_o), 1);
        idle();
        wr(A_SEED, 32'h77);
        cycles(5);
        rd(A_CNT, r); chk("R5", "count while enabled", 128'(r), 2);
        chk("R5", "lane 2 while enabled", 128'(seed_o[23:16]), 0);
        idle();
        wr(A_CTRL, 32'h0);

        // R4 count register is read-only
        wr(A_CNT, 32'h5);
        rd(A_CNT, r); chk("R4", "count after write to it", 128'(r), 2);
        idle();

        // Fill the remaining bytes with software-style polling
        for (int i = 2; i < SB; i++) begin
            wr(A_SEED, {24'hABCDEF, pat(i)});
            cycles(ACC + 1);
            if (i == SB - 2) chk("R7", "valid low at 15 bytes", 128'(seed_valid_o), 0);
        end
        exp_seed = '0;
        exp_seed[7:0]  = 8'h5A;
        exp_seed[15:8] = 8'h11;
        for (int i = 2; i < SB; i++) exp_seed[i*8 +: 8] = pat(i);
        chk("R3", "full seed", seed_o, exp_seed);
        chk("R7", "valid at 16 bytes", 128'(seed_valid_o), 1);
        rd(A_CNT, r); chk("R4", "count reads 16", 128'(r), 16);
        idle();

        // R6 / R10 writes after full
        wr(A_SEED, 32'h33);
        cycles(4);
        wr(A_SEED, 32'h44);
        cycles(4);
        rd(A_CNT, r); chk("R10", "count capped at 16", 128'(r), 16);
        chk("R6", "seed unchanged when full", seed_o, exp_seed);
        rd(A_SEED, r); chk("R9", "seed register reads 0", 128'(r), 0);
        idle();

        // R7 sticky through enable toggling
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        cycles(2);
        chk("R7", "valid sticky", 128'(seed_valid_o), 1);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R1", "seed after second reset", seed_o, '0);
        chk("R1", "valid after second reset", 128'(seed_valid_o), 0);
        rd(A_CNT, r); chk("R1", "count after second reset", 128'(r), 0);
        idle();
        cycles(3);

        summary();
        $finish;
    end

endmodule